// File: doc/BRIEF.md
# Flash page-load write controller

This block sits behind a byte-wide flash bus and turns a burst of host byte writes into one timed page commit. The bus strobes (chip-enable, output-enable, write-enable, all active low) arrive already sampled into the clock domain. A qualified write strobe hands one byte to a 128-byte page buffer.

The first accepted byte opens a load window and fixes the page address for that window. Each later byte on the same page keeps the window open. When no byte has been accepted for a programmable number of cycles, the window closes. The block then runs an internal write of fixed length, with `busy_o` high, and at its end commits the whole page to the behavioural storage at once. A byte position that was not loaded in the window is committed as FF.

Reads return stored bytes combinationally from the addressed location. All time limits are clock-cycle counts so that simulation stays short. The storage holds a small number of page slots, and the low page-address bits pick the slot.

Top module: `flash_page_writer`

## Requirements
- R1: After reset `busy_o` and `page_err_o` are low and every stored byte reads FF. `data_o` shows the byte at `addr_i` while `ce_ni`=0, `oe_ni`=0 and `we_ni`=1. In every other strobe state `data_o` is 00.
- R2: A write strobe is active while `ce_ni`=0, `we_ni`=0 and `oe_ni`=1. The address is taken in the first active cycle and the data in the last active cycle. The byte is offered when the strobe ends because `ce_ni` or `we_ni` goes high.
- R3: A strobe that is active for fewer than GLITCH_CYC cycles is dropped. A strobe that ends because `oe_ni` falls while `ce_ni` and `we_ni` are still low is also dropped.
- R4: The first accepted byte opens a load window. Every accepted byte on the window's page restarts an idle count, and `busy_o` rises LOAD_TMO cycles after the last such byte, within two cycles either way.
- R5: Within one window, bytes may be loaded in any order. A byte offset written twice keeps the later value. At commit, every offset not loaded in the window becomes FF, even if it held other data before.
- R6: `busy_o` stays high for WR_CYC cycles. While it is high, reads return the previous page contents. All 128 bytes change together when `busy_o` falls.
- R7: A byte whose page address (address bits 17..7) differs from the window's page is not stored, does not restart the idle count, and sets `page_err_o`. `page_err_o` then stays high until reset.
- R8: Write strobes that end while `busy_o` is high are ignored. They neither store data nor open a new window.
- R9: Strobes that end during the first PWRUP_CYC cycles after reset are ignored.
- R10: The storage keeps STORE_PAGES page slots. A page is stored in the slot given by its page address modulo STORE_PAGES, and reads decode the slot the same way: with 8 slots, pages 1 and 9 share a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low, already synchronous |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 18 | Byte address: bits 17..7 select the page, bits 6..0 the offset |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data, 00 when no read is in progress |
| busy_o | output | 1 | Internal page write in progress |
| page_err_o | output | 1 | Sticky flag: a byte was dropped because its page did not match the window |

## Verification
A wrong sequencer state shows up first on `busy_o`. It rises too early or too late relative to the last accepted byte, stays high for the wrong number of cycles, or rises with no window open. All of these can be seen within one LOAD_TMO plus WR_CYC interval.

A corrupt buffer mask or a wrong slot decode stays hidden until the commit. It then shows as a wrong byte or a missing FF on the first read after `busy_o` falls. Faults in the strobe qualifier show as a byte that lands at the wrong offset, carries stale data, or opens a window it should not have opened.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } fpw_state_e;
endpackage

// File: rtl/fpw_strobe.sv
module fpw_strobe #(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int GLITCH_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              load_vld_o,
  output logic [ADDR_W-1:0] load_addr_o,
  output logic [DATA_W-1:0] load_data_o
);
  localparam int CNT_W = $clog2(GLITCH_CYC + 1) < 1 ? 1 : $clog2(GLITCH_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(GLITCH_CYC);

  logic              act, act_q, inhibit;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign act     = ~ce_ni & ~we_ni & oe_ni;
  assign inhibit = ~ce_ni & ~we_ni & ~oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= act;
      if (act) begin
        data_q <= data_i;
        if (!act_q) begin
          addr_q <= addr_i;
          cnt_q  <= CNT_W'(1);
        end else if (cnt_q < CNT_MIN) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // strobe ends on ce/we rise only; an oe drop aborts it
  assign load_vld_o  = act_q & ~act & ~inhibit & (cnt_q >= CNT_MIN);
  assign load_addr_o = addr_q;
  assign load_data_o = data_q;
endmodule

// File: rtl/fpw_seq.sv
module fpw_seq
  import fpw_pkg::*;
#(
  parameter int PAGE_W    = 11,
  parameter int SLOT_W    = 3,
  parameter int LOAD_TMO  = 50,
  parameter int WR_CYC    = 100,
  parameter int PWRUP_CYC = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_vld_i,
  input  logic [PAGE_W-1:0] load_page_i,
  output logic              buf_we_o,
  output logic              buf_clr_o,
  output logic              commit_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              pwr_ok_o
);
  localparam int TMAX = (LOAD_TMO > WR_CYC) ? LOAD_TMO : WR_CYC;
  localparam int TM_W = $clog2(TMAX + 1);
  localparam int PW_W = $clog2(PWRUP_CYC + 2);
  localparam logic [TM_W-1:0] TMO_LAST = TM_W'(LOAD_TMO - 1);
  localparam logic [TM_W-1:0] WR_LAST  = TM_W'(WR_CYC - 1);
  localparam logic [PW_W-1:0] PW_END   = PW_W'(PWRUP_CYC);

  fpw_state_e        state_q;
  logic [TM_W-1:0]   tmr_q;
  logic [PW_W-1:0]   pw_q;
  logic [PAGE_W-1:0] page_q;
  logic              err_q;
  logic              accept, match;

  assign pwr_ok_o = (pw_q == PW_END);
  assign accept   = load_vld_i & pwr_ok_o & (state_q != ST_PROG);
  assign match    = (state_q == ST_IDLE) | (load_page_i == page_q);
  assign buf_we_o = accept & match;
  assign commit_o = (state_q == ST_PROG) & (tmr_q == WR_LAST);
  assign buf_clr_o = commit_o;
  assign busy_o   = (state_q == ST_PROG);
  assign slot_o   = page_q[SLOT_W-1:0];
  assign err_o    = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_q <= '0;
    end else if (!pwr_ok_o) begin
      pw_q <= pw_q + PW_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (accept && !match) begin
      err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      page_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            page_q  <= load_page_i;
            tmr_q   <= '0;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (buf_we_o) begin
            tmr_q <= '0;
          end else if (tmr_q == TMO_LAST) begin
            tmr_q   <= '0;
            state_q <= ST_PROG;
          end else begin
            tmr_q <= tmr_q + TM_W'(1);
          end
        end
        ST_PROG: begin
          if (commit_o) begin
            tmr_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            tmr_q <= tmr_q + TM_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpw_page_buf.sv
module fpw_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 7
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic                              clr_i,
  input  logic [OFS_W-1:0]                  idx_i,
  input  logic [DATA_W-1:0]                 data_i,
  output logic [(1<<OFS_W)*DATA_W-1:0]      page_o
);
  localparam int NB = 1 << OFS_W;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic              vld_q;
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q  <= 1'b0;
        byte_q <= '0;
      end else if (clr_i) begin
        vld_q <= 1'b0;
      end else if (we_i && idx_i == OFS_W'(b)) begin
        vld_q  <= 1'b1;
        byte_q <= data_i;
      end
    end
    // unloaded offsets commit as erased
    assign page_o[b*DATA_W +: DATA_W] = vld_q ? byte_q : '1;
  end
endmodule

// File: rtl/fpw_store.sv
module fpw_store #(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 7,
  parameter int SLOT_W = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         commit_i,
  input  logic [SLOT_W-1:0]            wr_slot_i,
  input  logic [(1<<OFS_W)*DATA_W-1:0] page_i,
  input  logic [SLOT_W-1:0]            rd_slot_i,
  input  logic [OFS_W-1:0]             rd_idx_i,
  output logic [DATA_W-1:0]            rd_data_o
);
  localparam int NB    = 1 << OFS_W;
  localparam int SLOTS = 1 << SLOT_W;

  logic [DATA_W-1:0] mem_q [SLOTS][NB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SLOTS; s++) begin
        for (int b = 0; b < NB; b++) begin
          mem_q[s][b] <= '1;
        end
      end
    end else if (commit_i) begin
      for (int b = 0; b < NB; b++) begin
        mem_q[wr_slot_i][b] <= page_i[b*DATA_W +: DATA_W];
      end
    end
  end

  assign rd_data_o = mem_q[rd_slot_i][rd_idx_i];
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int OFS_W       = 7,
  parameter int STORE_PAGES = 8,
  parameter int LOAD_TMO    = 50,
  parameter int WR_CYC      = 100,
  parameter int GLITCH_CYC  = 3,
  parameter int PWRUP_CYC   = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o,
  output logic              page_err_o
);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int SLOT_W = $clog2(STORE_PAGES);
  localparam int NB     = 1 << OFS_W;

  logic              load_vld;
  logic [ADDR_W-1:0] load_addr;
  logic [DATA_W-1:0] load_data;
  logic              buf_we, buf_clr, commit, pwr_ok;
  logic [SLOT_W-1:0] wr_slot;
  logic [NB*DATA_W-1:0] page_flat;
  logic [DATA_W-1:0] rd_data;
  logic              rd_en;

  fpw_strobe #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC)
  ) u_strobe (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .addr_i, .data_i,
    .load_vld_o(load_vld), .load_addr_o(load_addr), .load_data_o(load_data)
  );

  fpw_seq #(
    .PAGE_W(PAGE_W), .SLOT_W(SLOT_W), .LOAD_TMO(LOAD_TMO),
    .WR_CYC(WR_CYC), .PWRUP_CYC(PWRUP_CYC)
  ) u_seq (
    .clk_i, .rst_ni,
    .load_vld_i(load_vld),
    .load_page_i(load_addr[ADDR_W-1:OFS_W]),
    .buf_we_o(buf_we), .buf_clr_o(buf_clr), .commit_o(commit),
    .slot_o(wr_slot), .busy_o(busy_o), .err_o(page_err_o), .pwr_ok_o(pwr_ok)
  );

  fpw_page_buf #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_buf (
    .clk_i, .rst_ni, .we_i(buf_we), .clr_i(buf_clr),
    .idx_i(load_addr[OFS_W-1:0]), .data_i(load_data), .page_o(page_flat)
  );

  fpw_store #(.DATA_W(DATA_W), .OFS_W(OFS_W), .SLOT_W(SLOT_W)) u_store (
    .clk_i, .rst_ni, .commit_i(commit), .wr_slot_i(wr_slot), .page_i(page_flat),
    .rd_slot_i(addr_i[OFS_W +: SLOT_W]), .rd_idx_i(addr_i[OFS_W-1:0]),
    .rd_data_o(rd_data)
  );

  assign rd_en  = ~ce_ni & ~oe_ni & we_ni;
  assign data_o = rd_en ? rd_data : '0;
endmodule

// File: rtl/fpw_checker.sv
module fpw_checker #(
  parameter int DATA_W = 8,
  parameter int WR_CYC = 100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              we_ni,
  input logic [DATA_W-1:0] data_o,
  input logic              busy_o,
  input logic              page_err_o,
  input logic              pwr_ok,
  input logic              commit,
  input logic              load_vld
);
  logic [31:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt_q <= '0;
    else if (busy_o) busy_cnt_q <= busy_cnt_q + 32'd1;
    else busy_cnt_q <= '0;
  end

  a_r6_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_cnt_q == WR_CYC);

  a_r6_commit_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> busy_o);

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_err_o |=> page_err_o);

  a_r9_pwrup_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok |-> !busy_o && !page_err_o);

  a_r1_bus_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ce_ni && !oe_ni && we_ni) |-> data_o == '0);

  a_r2_strobe_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_vld |=> !load_vld);
endmodule

bind flash_page_writer fpw_checker #(.DATA_W(DATA_W), .WR_CYC(WR_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
  .data_o(data_o), .busy_o(busy_o), .page_err_o(page_err_o),
  .pwr_ok(pwr_ok), .commit(commit), .load_vld(load_vld)
);

// File: tb/flash_page_writer_bench.sv
module flash_page_writer_bench;
  localparam int LOAD_TMO = 50;
  localparam int WR_CYC   = 100;
  localparam int GLITCH   = 3;
  localparam int PWRUP    = 40;
  localparam int LIMIT    = 1000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [17:0] addr_i = '0;
  logic [7:0]  data_i = '0, data_o;
  logic busy_o, page_err_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit saw_busy = 1'b0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) if (busy_o) saw_busy = 1'b1;

  flash_page_writer #(
    .STORE_PAGES(8), .LOAD_TMO(LOAD_TMO), .WR_CYC(WR_CYC),
    .GLITCH_CYC(GLITCH), .PWRUP_CYC(PWRUP)
  ) u_flash_page_writer (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .addr_i, .data_i,
    .data_o, .busy_o, .page_err_o
  );

  function automatic logic [17:0] adr(input int page, input int ofs);
    return 18'((page << 7) | ofs);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic strobe(input logic [17:0] a, input logic [7:0] d, input int len);
    @(negedge clk_i);
    addr_i = a; data_i = d; oe_ni = 1'b1; ce_ni = 1'b0; we_ni = 1'b0;
    repeat (len) @(negedge clk_i);
    we_ni = 1'b1;
    @(negedge clk_i);
    ce_ni = 1'b1;
  endtask

  task automatic rd(input logic [17:0] a, output int v);
    @(negedge clk_i);
    addr_i = a; ce_ni = 1'b0; oe_ni = 1'b0; we_ni = 1'b1;
    #1 v = int'(data_o);
    ce_ni = 1'b1; oe_ni = 1'b1;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!busy_o && n < LIMIT) begin @(negedge clk_i); n++; end
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    while (busy_o && n < LIMIT) begin @(negedge clk_i); n++; end
  endtask

  task automatic commit_wait;
    int n;
    wait_rise(n);
    wait_fall(n);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check("R1 busy after reset", busy_o, 0);
    check("R1 err after reset", page_err_o, 0);
    check("R1 data_o idle", data_o, 8'h00);
  endtask

  task automatic t_pwrup;
    int v;
    saw_busy = 1'b0;
    strobe(adr(0, 4), 8'h5a, 4);
    repeat (PWRUP + LOAD_TMO + 20) @(negedge clk_i);
    check("R9 no window in power-up", int'(saw_busy), 0);
    rd(adr(0, 4), v);
    check("R9 byte not stored", v, 8'hff);
    rd(adr(3, 77), v);
    check("R1 erased after reset", v, 8'hff);
  endtask

  task automatic t_page;
    int n, v;
    strobe(adr(2, 5), 8'h11, 4);
    strobe(adr(2, 0), 8'h22, 4);
    strobe(adr(2, 127), 8'h33, 5);
    strobe(adr(2, 5), 8'h44, 4);
    wait_rise(n);
    check_rng("R4 window close latency", n, LOAD_TMO - 2, LOAD_TMO + 2);
    rd(adr(2, 5), v);
    check("R6 old data during busy", v, 8'hff);
    wait_fall(n);
    check_rng("R6 busy length", n + 1, WR_CYC - 2, WR_CYC + 2);
    rd(adr(2, 0), v);   check("R5 offset 0", v, 8'h22);
    rd(adr(2, 5), v);   check("R5 rewritten offset keeps last", v, 8'h44);
    rd(adr(2, 127), v); check("R5 offset 127", v, 8'h33);
    rd(adr(2, 6), v);   check("R5 unloaded offset FF", v, 8'hff);
    strobe(adr(2, 0), 8'h55, 4);
    commit_wait();
    rd(adr(2, 0), v);   check("R5 reload offset 0", v, 8'h55);
    rd(adr(2, 5), v);   check("R5 prior data erased to FF", v, 8'hff);
  endtask

  task automatic t_window;
    int v;
    strobe(adr(3, 10), 8'h01, 4);
    repeat (LOAD_TMO * 2 / 3) @(negedge clk_i);
    check("R4 window open mid idle", busy_o, 0);
    strobe(adr(3, 11), 8'h02, 4);
    repeat (LOAD_TMO * 2 / 3) @(negedge clk_i);
    check("R4 idle count restarted", busy_o, 0);
    commit_wait();
    rd(adr(3, 10), v); check("R4 first byte", v, 8'h01);
    rd(adr(3, 11), v); check("R4 second byte", v, 8'h02);
  endtask

  task automatic t_glitch;
    int v;
    saw_busy = 1'b0;
    strobe(adr(3, 20), 8'h66, GLITCH - 1);
    // strobe aborted by oe falling
    @(negedge clk_i);
    addr_i = adr(3, 21); data_i = 8'h67; ce_ni = 1'b0; we_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    oe_ni = 1'b0;
    @(negedge clk_i);
    ce_ni = 1'b1; we_ni = 1'b1; oe_ni = 1'b1;
    repeat (LOAD_TMO + 20) @(negedge clk_i);
    check("R3 short or aborted strobe opens nothing", int'(saw_busy), 0);
    rd(adr(3, 20), v); check("R3 short strobe not stored", v, 8'hff);
    rd(adr(3, 21), v); check("R3 oe abort not stored", v, 8'hff);
  endtask

  task automatic t_capture;
    int v;
    @(negedge clk_i);
    addr_i = adr(4, 8); data_i = 8'h0f; oe_ni = 1'b1; ce_ni = 1'b0; we_ni = 1'b0;
    @(negedge clk_i);
    addr_i = adr(4, 9); data_i = 8'h70;
    repeat (3) @(negedge clk_i);
    we_ni = 1'b1;
    @(negedge clk_i);
    ce_ni = 1'b1;
    commit_wait();
    rd(adr(4, 8), v); check("R2 first-cycle addr, last-cycle data", v, 8'h70);
    rd(adr(4, 9), v); check("R2 later addr unused", v, 8'hff);
  endtask

  task automatic t_mismatch;
    int v;
    check("R7 flag clear before", page_err_o, 0);
    strobe(adr(5, 0), 8'h77, 4);
    strobe(adr(6, 0), 8'h88, 4);
    @(negedge clk_i);
    check("R7 flag set", page_err_o, 1);
    commit_wait();
    rd(adr(5, 0), v); check("R7 matching byte stored", v, 8'h77);
    rd(adr(6, 0), v); check("R7 foreign byte dropped", v, 8'hff);
  endtask

  task automatic t_busy;
    int n, v;
    strobe(adr(7, 3), 8'h99, 4);
    wait_rise(n);
    strobe(adr(7, 4), 8'haa, 4);
    strobe(adr(1, 0), 8'hab, 4);
    wait_fall(n);
    saw_busy = 1'b0;
    repeat (LOAD_TMO + 20) @(negedge clk_i);
    check("R8 no window from busy strobes", int'(saw_busy), 0);
    rd(adr(7, 3), v); check("R8 pre-busy byte", v, 8'h99);
    rd(adr(7, 4), v); check("R8 busy strobe dropped", v, 8'hff);
    rd(adr(1, 0), v); check("R8 busy strobe other page dropped", v, 8'hff);
  endtask

  task automatic t_alias;
    int v;
    strobe(adr(9, 2), 8'hbb, 4);
    commit_wait();
    rd(adr(1, 2), v); check("R10 slot alias read", v, 8'hbb);
    rd(adr(9, 2), v); check("R10 direct read", v, 8'hbb);
    check("R7 flag still sticky", page_err_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_pwrup();
    t_page();
    t_window();
    t_glitch();
    t_capture();
    t_mismatch();
    t_busy();
    t_alias();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule